// File: doc/BRIEF.md
# Byte-wide Packet Switch Fabric

This block is a crossbar that joins a set of 8-bit source ports to a set of 8-bit destination ports on one clock. A source opens a path in-band. After it goes idle, the first byte it writes is a destination code, and three zero bytes follow to fill out a 4-byte header burst. Once the header is in, the source waits for the destination. A fixed-priority arbiter per destination grants one waiting source. The fabric then forwards that source's write strobe and byte to the destination in the same cycle. This continues until the destination pulses its done input, which frees the destination and returns the source to idle.

Back-pressure runs the other way on a hold output per source. Hold is high while the source waits for a destination that is busy or not yet granted. While the source is connected, hold follows the destination's full input. Sources sample hold only between 4-byte bursts, so a destination raises full while it still has room for one more burst. Destination codes 0 to N_DST-2 select the port with the same index. The code HI_CODE selects the last port. Any other code is unpopulated.

Top module: `byte_switch_fabric`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, every src_hold_o bit and every dst_we_o bit is 0.
- R2: A path opens only after four header bytes (code then three filler bytes). No dst_we_o bit rises because of header bytes. In the cycle after the fourth byte, hold is 1. In the cycle after that, hold falls if the destination was free.
- R3: While a source is connected, each src_we_i pulse appears on dst_we_o of its destination in the same cycle, with src_data_i copied to that destination's 8-bit data lane.
- R4: A source that has sent its header for a destination owned by another source keeps src_hold_o at 1 for as long as that ownership lasts.
- R5: While a source is connected, its src_hold_o equals dst_full_i of its destination.
- R6: A dst_done_i pulse on a busy destination releases it. The owning source drops to idle with hold 0, and its next header opens a fresh path.
- R7: When several sources wait for the same free destination in the same cycle, the lowest-indexed one is granted, and the others keep hold at 1.
- R8: A header whose code is unpopulated is consumed and dropped. No path opens, hold stays 0, and the next header from that source is decoded normally.
- R9: Codes 0 to N_DST-2 select the destination of equal index. Code HI_CODE (default 0xF0) selects destination N_DST-1.
- R10: A source waiting on a busy destination is granted in the cycle after the destination's done pulse. Its hold is 1 in the first cycle after the pulse and 0 in the next.
- R11: Bytes written by a source that is waiting and not yet granted never reach any destination.
- R12: A dst_done_i pulse on a destination that is not busy has no effect on any existing path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_we_i | input | N_SRC | Byte strobe per source |
| src_data_i | input | 8*N_SRC | Byte per source, source s in bits 8s+7:8s |
| src_hold_o | output | N_SRC | Back-pressure per source, sampled between bursts |
| dst_we_o | output | N_DST | Byte strobe per destination |
| dst_data_o | output | 8*N_DST | Byte per destination, destination d in bits 8d+7:8d |
| dst_full_i | input | N_DST | Destination cannot take another burst |
| dst_done_i | input | N_DST | One-cycle pulse that ends the current path |

## Verification
The bench builds the fabric with three sources and four destinations, leaving HI_CODE at 0xF0. In that build, codes 0, 1 and 2 map directly, 0xF0 reaches the top port, and a code such as 0x05 falls in the unpopulated gap. Three sources are enough for two to contend for one destination while a third sits on another path. The upper-code mapping, the dropped-header path and the priority order can therefore all be exercised alongside a live connection.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HDR  = 2'd1,
    S_WAIT = 2'd2,
    S_CONN = 2'd3
  } src_state_e;
endpackage

// File: rtl/sf_addr_dec.sv
module sf_addr_dec #(
  parameter int          N_DST   = 4,
  parameter logic [7:0]  HI_CODE = 8'hF0,
  localparam int         IW      = (N_DST > 1) ? $clog2(N_DST) : 1
) (
  input  logic [7:0]    code_i,
  output logic [IW-1:0] idx_o,
  output logic          hit_o
);
  always_comb begin
    idx_o = '0;
    hit_o = 1'b0;
    if (code_i < 8'(N_DST - 1)) begin
      idx_o = code_i[IW-1:0];
      hit_o = 1'b1;
    end else if (code_i == HI_CODE) begin
      idx_o = IW'(N_DST - 1);
      hit_o = 1'b1;
    end
  end
endmodule

// File: rtl/sf_src_node.sv
module sf_src_node
  import sf_pkg::*;
#(
  parameter int          N_DST   = 4,
  parameter logic [7:0]  HI_CODE = 8'hF0,
  localparam int         IW      = (N_DST > 1) ? $clog2(N_DST) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    data_i,
  input  logic          grant_i,
  input  logic          release_i,
  input  logic          dst_full_i,
  output logic          req_o,
  output logic [IW-1:0] dst_idx_o,
  output logic          hold_o
);
  src_state_e    state_q;
  logic [1:0]    cnt_q;
  logic [IW-1:0] idx_q;
  logic          ok_q;
  logic [IW-1:0] dec_idx;
  logic          dec_hit;

  sf_addr_dec #(.N_DST(N_DST), .HI_CODE(HI_CODE)) u_dec (
    .code_i(data_i), .idx_o(dec_idx), .hit_o(dec_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (we_i) begin
          idx_q   <= dec_idx;
          ok_q    <= dec_hit;
          cnt_q   <= 2'd1;
          state_q <= S_HDR;
        end
        S_HDR: if (we_i) begin
          cnt_q <= cnt_q + 2'd1;
          // filler bytes are counted, not inspected
          if (cnt_q == 2'd3) state_q <= ok_q ? S_WAIT : S_IDLE;
        end
        S_WAIT: if (grant_i) state_q <= S_CONN;
        S_CONN: if (release_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_o     = (state_q == S_WAIT);
  assign dst_idx_o = idx_q;
  assign hold_o    = (state_q == S_WAIT) || ((state_q == S_CONN) && dst_full_i);

  a_r8_bad_code_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HDR && we_i && cnt_q == 2'd3 && !ok_q) |=> (state_q == S_IDLE && !hold_o));
  a_r6_release_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CONN && release_i) |=> (state_q == S_IDLE));
  a_r4_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !grant_i) |=> hold_o);
  a_r2_header_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && we_i) |=> (state_q == S_HDR));
endmodule

// File: rtl/sf_dst_arb.sv
module sf_dst_arb #(
  parameter int  N_SRC = 4,
  localparam int SW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             done_i,
  output logic [N_SRC-1:0] gnt_o,
  output logic             busy_o,
  output logic [SW-1:0]    owner_o
);
  logic          busy_q;
  logic [SW-1:0] owner_q;
  logic [SW-1:0] gnt_idx;

  // lowest index wins
  always_comb begin
    gnt_o   = '0;
    gnt_idx = '0;
    if (!busy_q) begin
      for (int s = N_SRC - 1; s >= 0; s--) begin
        if (req_i[s]) begin
          gnt_o   = '0;
          gnt_o[s] = 1'b1;
          gnt_idx = SW'(s);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (busy_q) begin
      if (done_i) busy_q <= 1'b0;
    end else if (|gnt_o) begin
      busy_q  <= 1'b1;
      owner_q <= gnt_idx;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;

  a_r7_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r7_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> (((gnt_o - 1'b1) & req_i) == '0));
  a_r6_done_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> !busy_q);
  a_r12_done_idle_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && done_i && req_i == '0) |=> !busy_q);
  a_r10_owner_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> (busy_q && $stable(owner_q)));
endmodule

// File: rtl/byte_switch_fabric.sv
module byte_switch_fabric
  import sf_pkg::*;
#(
  parameter int          N_SRC   = 4,
  parameter int          N_DST   = 4,
  parameter logic [7:0]  HI_CODE = 8'hF0,
  localparam int         SW      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int         IW      = (N_DST > 1) ? $clog2(N_DST) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_SRC-1:0]          src_we_i,
  input  logic [N_SRC*BYTE_W-1:0]   src_data_i,
  output logic [N_SRC-1:0]          src_hold_o,
  output logic [N_DST-1:0]          dst_we_o,
  output logic [N_DST*BYTE_W-1:0]   dst_data_o,
  input  logic [N_DST-1:0]          dst_full_i,
  input  logic [N_DST-1:0]          dst_done_i
);
  logic [BYTE_W-1:0] src_byte  [N_SRC];
  logic [IW-1:0]     s_idx     [N_SRC];
  logic [N_SRC-1:0]  s_req, s_grant, s_release, s_full;
  logic [N_SRC-1:0]  d_req     [N_DST];
  logic [N_SRC-1:0]  d_gnt     [N_DST];
  logic [N_DST-1:0]  d_busy;
  logic [SW-1:0]     d_owner   [N_DST];

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_byte[s] = src_data_i[s*BYTE_W +: BYTE_W];
    assign s_full[s]   = dst_full_i[s_idx[s]];
    sf_src_node #(.N_DST(N_DST), .HI_CODE(HI_CODE)) u_node (
      .clk_i, .rst_ni,
      .we_i(src_we_i[s]), .data_i(src_byte[s]),
      .grant_i(s_grant[s]), .release_i(s_release[s]), .dst_full_i(s_full[s]),
      .req_o(s_req[s]), .dst_idx_o(s_idx[s]), .hold_o(src_hold_o[s])
    );
  end

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    always_comb begin
      for (int s = 0; s < N_SRC; s++) d_req[d][s] = s_req[s] && (s_idx[s] == IW'(d));
    end
    sf_dst_arb #(.N_SRC(N_SRC)) u_arb (
      .clk_i, .rst_ni,
      .req_i(d_req[d]), .done_i(dst_done_i[d]),
      .gnt_o(d_gnt[d]), .busy_o(d_busy[d]), .owner_o(d_owner[d])
    );
    assign dst_we_o[d] = d_busy[d] && src_we_i[d_owner[d]];
    assign dst_data_o[d*BYTE_W +: BYTE_W] = d_busy[d] ? src_byte[d_owner[d]] : '0;
  end

  always_comb begin
    s_grant   = '0;
    s_release = '0;
    for (int d = 0; d < N_DST; d++) begin
      s_grant = s_grant | d_gnt[d];
      for (int s = 0; s < N_SRC; s++)
        if (d_busy[d] && dst_done_i[d] && d_owner[d] == SW'(s)) s_release[s] = 1'b1;
    end
  end

  // one source owns at most one destination
  for (genvar a = 0; a < N_DST; a++) begin : g_pa
    for (genvar b = a + 1; b < N_DST; b++) begin : g_pb
      a_r3_one_to_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (d_busy[a] && d_busy[b]) |-> (d_owner[a] != d_owner[b]));
    end
  end
endmodule

// File: tb/tb_byte_switch_fabric.sv
module tb_byte_switch_fabric;
  localparam int NS = 3;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] src_we = '0;
  logic [NS*8-1:0] src_data = '0;
  logic [NS-1:0] src_hold;
  logic [ND-1:0] dst_we;
  logic [ND*8-1:0] dst_data;
  logic [ND-1:0] dst_full = '0;
  logic [ND-1:0] dst_done = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  byte_switch_fabric #(.N_SRC(NS), .N_DST(ND), .HI_CODE(8'hF0)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .src_we_i(src_we), .src_data_i(src_data), .src_hold_o(src_hold),
    .dst_we_o(dst_we), .dst_data_o(dst_data),
    .dst_full_i(dst_full), .dst_done_i(dst_done)
  );

  // {we, full, data, exp_we, exp_hold} on a path src0 -> dest3
  localparam logic [11:0] VEC [6] = '{
    {1'b1, 1'b0, 8'hA5, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h3C, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'hFF, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'h77, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hFF, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int s, input logic we, input logic [7:0] b);
    src_we[s] = we;
    src_data[s*8 +: 8] = b;
  endtask

  // 4-byte header from every source in mask; returns in the first WAIT cycle
  task automatic hdr(input logic [NS-1:0] mask, input logic [7:0] code);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      for (int s = 0; s < NS; s++)
        if (mask[s]) drive(s, 1'b1, (i == 0) ? code : 8'h00);
      #1 chk("R2 no forwarding of header", 32'(dst_we), 32'h0);
    end
    @(negedge clk);
    src_we = '0;
    #1;
  endtask

  task automatic pulse_done(input logic [ND-1:0] m);
    @(negedge clk);
    dst_done = m;
    @(negedge clk);
    dst_done = '0;
    #1;
  endtask

  initial begin
    #2;
    chk("R1 hold in reset", 32'(src_hold), 32'h0);
    chk("R1 dst_we in reset", 32'(dst_we), 32'h0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R1 hold after reset", 32'(src_hold), 32'h0);
    chk("R1 dst_we after reset", 32'(dst_we), 32'h0);

    // R9 upper code, R2 header timing, R3/R5 forwarding table
    hdr(3'b001, 8'hF0);
    chk("R2 hold in wait cycle", 32'(src_hold[0]), 32'h1);
    @(negedge clk); #1;
    chk("R2 hold after grant", 32'(src_hold[0]), 32'h0);
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      drive(0, VEC[v][11], VEC[v][9:2]);
      dst_full[3] = VEC[v][10];
      #1;
      chk("R3 R9 dst_we", 32'(dst_we), VEC[v][1] ? 32'h8 : 32'h0);
      if (VEC[v][1]) chk("R3 dst data", 32'(dst_data[31:24]), 32'(VEC[v][9:2]));
      chk("R5 hold follows full", 32'(src_hold[0]), 32'(VEC[v][0]));
    end
    @(negedge clk);
    src_we = '0; dst_full = '0;

    // R12 done on an idle destination
    pulse_done(4'b0010);
    drive(0, 1'b1, 8'h11);
    #1;
    chk("R12 path intact", 32'(dst_we), 32'h8);
    chk("R12 data intact", 32'(dst_data[31:24]), 32'h11);
    @(negedge clk); src_we = '0;

    // R4 / R11 contention on dest3
    hdr(3'b010, 8'hF0);
    chk("R4 hold while owned", 32'(src_hold[1]), 32'h1);
    @(negedge clk);
    drive(1, 1'b1, 8'h99);
    #1;
    chk("R4 hold still owned", 32'(src_hold[1]), 32'h1);
    chk("R11 waiting byte not forwarded", 32'(dst_we), 32'h0);
    @(negedge clk); src_we = '0;

    // R10 / R6 handover after done
    pulse_done(4'b1000);
    chk("R10 hold first cycle after done", 32'(src_hold[1]), 32'h1);
    chk("R6 old owner idle", 32'(src_hold[0]), 32'h0);
    @(negedge clk);
    drive(1, 1'b1, 8'h5A);
    #1;
    chk("R10 hold after regrant", 32'(src_hold[1]), 32'h0);
    chk("R10 new owner forwards", 32'(dst_we), 32'h8);
    chk("R10 new owner data", 32'(dst_data[31:24]), 32'h5A);
    @(negedge clk); src_we = '0;

    // R6 released source reconnects, R9 direct code
    hdr(3'b001, 8'h01);
    chk("R6 wait after new header", 32'(src_hold[0]), 32'h1);
    @(negedge clk);
    drive(0, 1'b1, 8'hC3);
    #1;
    chk("R6 reconnected hold", 32'(src_hold[0]), 32'h0);
    chk("R9 code 1 to dest1", 32'(dst_we), 32'h2);
    chk("R9 dest1 data", 32'(dst_data[15:8]), 32'hC3);
    @(negedge clk); src_we = '0;

    // R7 simultaneous request
    pulse_done(4'b1010);
    hdr(3'b011, 8'h02);
    chk("R7 both waiting", 32'(src_hold[1:0]), 32'h3);
    @(negedge clk);
    drive(0, 1'b1, 8'h42);
    #1;
    chk("R7 lower index granted", 32'(src_hold[1:0]), 32'h2);
    chk("R7 winner forwards", 32'(dst_we), 32'h4);
    chk("R7 winner data", 32'(dst_data[23:16]), 32'h42);
    @(negedge clk); src_we = '0;

    // R8 unpopulated code
    hdr(3'b100, 8'h05);
    chk("R8 no wait on bad code", 32'(src_hold[2]), 32'h0);
    @(negedge clk); #1;
    chk("R8 still idle", 32'(src_hold[2]), 32'h0);
    hdr(3'b100, 8'h00);
    chk("R8 next header decoded", 32'(src_hold[2]), 32'h1);
    @(negedge clk);
    drive(2, 1'b1, 8'h81);
    #1;
    chk("R8 path to dest0", 32'(dst_we), 32'h1);
    chk("R8 dest0 data", 32'(dst_data[7:0]), 32'h81);
    @(negedge clk); src_we = '0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule